// File: doc/BRIEF.md
# Power-On Frequency Strap Sampler

Some clock pins also carry a configuration strap. This block uses two such pins. It samples them once after power-up, while both pin buffers are held in high impedance. For a fixed number of reference-clock cycles after the power-good signal rises, the output-enables of both shared buffers stay low. During this time an external pull resistor on each pin sets its level. The two pin levels pass through a two-stage synchronizer. On the last cycle of the window the block captures them into a 2-bit select code and turns both buffers on. One cycle after that it raises a ready flag.

The captured code stays fixed until power-good falls again. Pin activity after the window, such as the clock toggling on the same pins, has no effect on the code. The block decodes the code into a CPU frequency selection and an SDRAM frequency selection for the clock generator downstream.

Top module: `strap_sampler`

## Requirements
- R1: While `pwrGood` is low, and for the first WINDOW_CYCLES rising edges after it rises, both bits of `outEn` are 0.
- R2: Both bits of `outEn` become 1 together on rising edge number WINDOW_CYCLES after `pwrGood` rises. They then stay 1 while `pwrGood` is high.
- R3: The captured code `fsLatched` has bit 0 from `pinFs0` and bit 1 from `pinFs1`. Each bit takes the pin level that was present at rising edge WINDOW_CYCLES-2. A change after that edge is not captured.
- R4: After the capture, changes on `pinFs0` and `pinFs1` have no effect on `fsLatched`, `cpuSel` or `sdramSel` until `pwrGood` falls.
- R5: `cpuSel` decodes the code {pinFs1,pinFs0} with the encoding 0 = 66 MHz, 1 = 100 MHz, 2 = 133 MHz. Code 00 gives 0, code 01 gives 1, and codes 10 and 11 give 2.
- R6: `sdramSel` decodes the same code with the encoding 0 = 100 MHz, 1 = 133 MHz. It is 1 only for code 10.
- R7: `ready` rises exactly one rising edge after `outEn` becomes 1, and it is never 1 while `outEn` is 0.
- R8: Driving `pwrGood` low immediately clears `outEn`, `ready` and `fsLatched`, without waiting for a clock edge. A later rise of `pwrGood` starts a new sampling window with a new capture.
- R9: Before the capture, `fsLatched` is 00, `cpuSel` is 0 and `sdramSel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock that times the window |
| pwrGood | input | 1 | Power-good; low acts as an asynchronous reset of the whole block (a power cycle) |
| pinFs0 | input | 1 | Input level of shared pin 0 |
| pinFs1 | input | 1 | Input level of shared pin 1 |
| outEn | output | 2 | Output-enables of the two shared buffers; 0 means high impedance |
| fsLatched | output | 2 | Captured code {pin1, pin0} |
| cpuSel | output | 2 | CPU frequency selection (0 = 66, 1 = 100, 2 = 133 MHz) |
| sdramSel | output | 1 | SDRAM frequency selection (0 = 100, 1 = 133 MHz) |
| ready | output | 1 | Selection is valid and the buffers are driving |

## Verification
The hardest case to reach from the ports is a pin edge close to the end of the window. The synchronizer decides whether such an edge is captured. The bench changes the pins right after edge WINDOW_CYCLES-2 and expects the old level to be captured. It also applies a change a few edges earlier that must be captured. To reach the second power cycle, the bench drops `pwrGood` in the middle of normal operation. It then checks that the outputs clear at once and that a different code is captured the next time. Each run uses a small window, so the bench can sweep all four codes across repeated power cycles.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    CPU_66  = 2'd0,
    CPU_100 = 2'd1,
    CPU_133 = 2'd2
  } cpu_freq_e;

  typedef enum logic {
    SDR_100 = 1'b0,
    SDR_133 = 1'b1
  } sdram_freq_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic driveOn;
  } strap_strobe_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic          refClk,
  input  logic          pwrGood,
  output strap_strobe_t strobe,
  output logic          bufOn,
  output logic          readyOut
);

  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  typedef enum logic {PH_SAMPLE = 1'b0, PH_RUN = 1'b1} phase_e;

  phase_e        phase;
  logic [CW-1:0] cnt;

  always_comb begin
    strobe.capture = (phase == PH_SAMPLE) && (cnt == LAST);
    strobe.driveOn = (phase == PH_RUN);
  end

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood) begin
      phase    <= PH_SAMPLE;
      cnt      <= '0;
      bufOn    <= 1'b0;
      readyOut <= 1'b0;
    end else begin
      if (phase == PH_SAMPLE) begin
        if (cnt == LAST) begin
          phase <= PH_RUN;
          bufOn <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      readyOut <= bufOn;
    end
  end

  // R1: counter never passes the last window cycle
  assert_count_bounded_R1: assert property (@(posedge refClk) disable iff (!pwrGood)
    cnt <= LAST);

  // R2: buffers turn on only right after the last window cycle
  assert_oe_at_window_end_R2: assert property (@(posedge refClk) disable iff (!pwrGood)
    $rose(bufOn) |-> $past(cnt) == LAST);

  // R2: once on, buffers stay on
  assert_oe_sticky_R2: assert property (@(posedge refClk) disable iff (!pwrGood)
    bufOn |=> bufOn);

  // R7: ready implies buffers on, and follows them by one edge
  assert_ready_after_oe_R7: assert property (@(posedge refClk) disable iff (!pwrGood)
    readyOut |-> bufOn);
  assert_ready_rise_R7: assert property (@(posedge refClk) disable iff (!pwrGood)
    $rose(bufOn) |=> readyOut);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int PINS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            refClk,
  input  logic            pwrGood,
  input  logic [PINS-1:0] pinIn,
  input  strap_strobe_t   strobe,
  output logic [PINS-1:0] codeLatched,
  output cpu_freq_e       cpuFreq,
  output sdram_freq_e     sdramFreq
);

  logic [PINS-1:0] syncStage [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge refClk or negedge pwrGood) begin
          if (!pwrGood) syncStage[0] <= '0;
          else          syncStage[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge refClk or negedge pwrGood) begin
          if (!pwrGood) syncStage[s] <= '0;
          else          syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood)            codeLatched <= '0;
    else if (strobe.capture) codeLatched <= syncStage[SYNC_STAGES-1];
  end

  always_comb begin
    unique case (codeLatched[1:0])
      2'b00:   begin cpuFreq = CPU_66;  sdramFreq = SDR_100; end
      2'b01:   begin cpuFreq = CPU_100; sdramFreq = SDR_100; end
      2'b10:   begin cpuFreq = CPU_133; sdramFreq = SDR_133; end
      default: begin cpuFreq = CPU_133; sdramFreq = SDR_100; end
    endcase
  end

  // R4: code is frozen once the buffers drive
  assert_code_frozen_R4: assert property (@(posedge refClk) disable iff (!pwrGood)
    strobe.driveOn |=> $stable(codeLatched));

  // R5: reserved CPU encoding never produced
  assert_cpu_legal_R5: assert property (@(posedge refClk) disable iff (!pwrGood)
    cpuFreq != 2'd3);

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic       refClk,
  input  logic       pwrGood,
  input  logic       pinFs0,
  input  logic       pinFs1,
  output logic [1:0] outEn,
  output logic [1:0] fsLatched,
  output logic [1:0] cpuSel,
  output logic       sdramSel,
  output logic       ready
);

  strap_strobe_t strobe;
  logic          bufOn;
  cpu_freq_e     cpuFreq;
  sdram_freq_e   sdramFreq;

  strap_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_ctrl (
    .refClk   (refClk),
    .pwrGood  (pwrGood),
    .strobe   (strobe),
    .bufOn    (bufOn),
    .readyOut (ready)
  );

  strap_datapath #(.PINS(2), .SYNC_STAGES(2)) u_dp (
    .refClk      (refClk),
    .pwrGood     (pwrGood),
    .pinIn       ({pinFs1, pinFs0}),
    .strobe      (strobe),
    .codeLatched (fsLatched),
    .cpuFreq     (cpuFreq),
    .sdramFreq   (sdramFreq)
  );

  assign outEn    = {2{bufOn}};
  assign cpuSel   = cpuFreq;
  assign sdramSel = sdramFreq;

  // R6: SDRAM 133 only for code 10 once valid
  assert_sdram_code_R6: assert property (@(posedge refClk) disable iff (!pwrGood)
    (ready && sdramSel) |-> (fsLatched == 2'b10));

  // R9: before buffers drive, selections sit at reset values
  assert_presample_zero_R9: assert property (@(posedge refClk) disable iff (!pwrGood)
    (outEn == 2'b00) |-> (fsLatched == 2'b00));

endmodule

// File: tb/sim_strap_sampler.sv
module sim_strap_sampler;

  localparam int WIN = 12;

  logic       clk = 1'b0;
  logic       pwrGood = 1'b0;
  logic       pin0 = 1'b0, pin1 = 1'b0;
  logic [1:0] outEn, fsLatched, cpuSel;
  logic       sdramSel, ready;
  int         nChecks = 0, nFails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  strap_sampler #(.WINDOW_CYCLES(WIN)) u0 (
    .refClk(clk), .pwrGood(pwrGood), .pinFs0(pin0), .pinFs1(pin1),
    .outEn(outEn), .fsLatched(fsLatched), .cpuSel(cpuSel),
    .sdramSel(sdramSel), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expCpu(input int code);
    return (code == 0) ? 0 : (code == 1) ? 1 : 2;
  endfunction

  function automatic int expSd(input int code);
    return (code == 2) ? 1 : 0;
  endfunction

  // Release power-good at a negedge; wait n further edges
  task automatic powerUp();
    @(negedge clk);
    pwrGood = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkDecoded(input int code, input string tag);
    check({tag, " R3 fsLatched"}, fsLatched, code);
    check({tag, " R5 cpuSel"}, cpuSel, expCpu(code));
    check({tag, " R6 sdramSel"}, sdramSel, expSd(code));
  endtask

  initial begin
    #(20 * 20000);
    $display("FAIL watchdog: actual running expected finished");
    nFails++; nChecks++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8 / R9: reset state
    edges(3);
    check("R8 outEn in reset", outEn, 0);
    check("R8 ready in reset", ready, 0);
    check("R9 fsLatched in reset", fsLatched, 0);
    check("R9 cpuSel in reset", cpuSel, 0);
    check("R9 sdramSel in reset", sdramSel, 0);

    // Sweep all codes, twice, with a power cycle between runs
    for (int rep = 0; rep < 2; rep++) begin
      for (int code = 0; code < 4; code++) begin
        int c;
        c = (rep == 0) ? code : 3 - code;
        pin0 = c[0]; pin1 = c[1];
        powerUp();
        edges(WIN - 1);
        check("R1 outEn before window end", outEn, 0);
        check("R9 fsLatched before capture", fsLatched, 0);
        edges(1);
        check("R2 outEn at window end", outEn, 3);
        check("R7 ready one edge late", ready, 0);
        checkDecoded(c, "sweep");
        edges(1);
        check("R7 ready high", ready, 1);
        // R4: pins toggle after capture, code must stay
        for (int k = 0; k < 6; k++) begin
          pin0 = ~pin0; pin1 = k[0];
          edges(1);
        end
        checkDecoded(c, "R4 after pin toggles");
        check("R2 outEn stays on", outEn, 3);
        // R8: asynchronous clear mid-cycle
        #3 pwrGood = 1'b0;
        #1;
        check("R8 outEn cleared", outEn, 0);
        check("R8 ready cleared", ready, 0);
        check("R8 fsLatched cleared", fsLatched, 0);
        edges(2);
      end
    end

    // R3 boundary: pins wrong early, corrected before edge WIN-2 -> captured
    pin0 = 1'b1; pin1 = 1'b1;
    powerUp();
    edges(WIN - 4);
    pin0 = 1'b0; pin1 = 1'b1;
    edges(4);
    checkDecoded(2, "R3 early change captured");
    pwrGood = 1'b0;
    edges(2);

    // R3 boundary: change after edge WIN-2 is not captured
    pin0 = 1'b1; pin1 = 1'b0;
    powerUp();
    edges(WIN - 2);
    pin0 = 1'b0; pin1 = 1'b1;
    edges(2);
    check("R2 outEn late-change run", outEn, 3);
    checkDecoded(1, "R3 late change ignored");
    pwrGood = 1'b0;
    edges(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule